// File: doc/BRIEF.md
# Codec Serial Control Port with Flag Outputs

This block is the device side of a codec's serial port. It derives the serial clock from the master clock. It then tracks frames, each opened by a frame-sync pulse. The frames take turns: a sample frame first, then a control frame, then a sample frame again. Sample frames are only shifted through as placeholders, and the output stays low during them. A control frame carries one 16-bit word from the host. The word either writes a byte into a small register file or reads one back.

During a control frame the block also returns an external status pin to the host. It captures the pin through a synchronizer when the frame opens and sends that value for the first half of the frame. On a read, the second half carries the addressed register. Two of the bits in the flag register drive general-purpose output pins. The host can therefore steer external hardware through the same serial link it uses for register access.

Top module: `codec_ctrl_port`

## Requirements
- R1: `sclk_o` is `mclk_i` divided by four, with a 50% duty cycle: two master cycles high, then two low.
- R2: After reset the first frame sync opens a sample frame, and each later frame sync flips the frame type. A word shifted in during a sample frame changes no register and no flag.
- R3: A control word is 16 bits, shifted MSB first. Bit 15 is the direction (1 = read, 0 = write), bits 14:8 are the register address and bits 7:0 are the data byte. A completed write stores the data byte at that address.
- R4: On a control read, `dout_o` carries the captured status value for the first 8 bits. The addressed register then follows for the next 8 bits, MSB first. Each bit is launched on a rising serial edge and is valid at the next falling edge.
- R5: On a control read, the data byte of the incoming word is ignored and the register file is unchanged.
- R6: `flag_o[0]` and `flag_o[1]` equal bits 0 and 1 of the register at address 2. They change on the master edge where the sixteenth bit of a write to that address is taken, and never before it.
- R7: The defined addresses are 0 to 3. A write to any other address changes nothing, and a read of any other address returns 0x00 in the data half.
- R8: `stat_i` passes through a two-flop synchronizer and is captured when a control frame's sync is taken. Changes after that point do not alter the status half of that frame.
- R9: A frame sync that arrives before 16 bits are taken restarts the bit count and opens a new frame of the next type. The incomplete word performs no write.
- R10: While reset is asserted, and right after it, `dout_o` and `flag_o` are low and all registers hold 0x00.
- R11: `dout_o` is low during sample frames, between frames, and in the data half of a control write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk_i | input | 1 | Master clock; all logic runs on its rising edge |
| rst_ni | input | 1 | Active-low reset |
| fs_i | input | 1 | Frame sync from the host, taken at falling serial edges |
| din_i | input | 1 | Serial data from the host, taken at falling serial edges |
| stat_i | input | 1 | Asynchronous external status input |
| sclk_o | output | 1 | Serial clock, master clock divided by four |
| dout_o | output | 1 | Serial data to the host, launched at rising serial edges |
| flag_o | output | 2 | General-purpose flag outputs from the flag register |

## Verification
Each output bit of a frame is launched on the master edge that raises the serial clock. It is checked 1 ns after the following falling serial edge, so every output sample sits half a serial period away from the edge that moves it. The flag pins are due on the same master edge that takes the sixteenth input bit. The bench reads them once just after that falling edge and once one bit earlier, which pins the update to exactly that bit. Status changes are made at least a whole serial period before a frame sync, which leaves room for the two synchronizer stages, or well after the sync, to show that the capture holds.

// File: rtl/codec_port_pkg.sv
package codec_port_pkg;

  localparam int CP_WORD_W = 16;
  localparam int CP_ADDR_W = 7;
  localparam int CP_DATA_W = 8;
  localparam int CP_HDR_W  = 1 + CP_ADDR_W;

  function automatic logic word_is_read(input logic [CP_WORD_W-1:0] w);
    return w[CP_WORD_W-1];
  endfunction

  function automatic logic [CP_ADDR_W-1:0] word_addr(input logic [CP_WORD_W-1:0] w);
    return w[CP_WORD_W-2 -: CP_ADDR_W];
  endfunction

  function automatic logic [CP_DATA_W-1:0] word_data(input logic [CP_WORD_W-1:0] w);
    return w[CP_DATA_W-1:0];
  endfunction

endpackage

// File: rtl/codec_sclk_div.sv
module codec_sclk_div #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic sclk_o,
  output logic rise_evt,
  output logic fall_evt
);
  logic [STAGES-1:0] q;
  logic [STAGES:0]   carry;

  assign carry[0] = 1'b1;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    assign carry[g+1] = carry[g] & q[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q[g] <= 1'b0;
      else if (carry[g]) q[g] <= ~q[g];
    end
  end

  assign sclk_o   = q[STAGES-1];
  assign rise_evt = carry[STAGES-1] & ~q[STAGES-1];
  assign fall_evt = carry[STAGES];
endmodule

// File: rtl/codec_sync.sv
module codec_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/codec_reg_bank.sv
module codec_reg_bank #(
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 8,
  parameter int REG_COUNT = 4,
  parameter int FLAG_ADDR = 2,
  parameter int FLAG_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [FLAG_W-1:0] flag_o
);
  logic [DATA_W-1:0] regs [REG_COUNT];

  for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   regs[g] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(g))      regs[g] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < REG_COUNT; i++) begin
      if (rd_addr == ADDR_W'(i)) rd_data = regs[i];
    end
  end

  assign flag_o = regs[FLAG_ADDR][FLAG_W-1:0];
endmodule

// File: rtl/codec_frame_engine.sv
module codec_frame_engine
  import codec_port_pkg::*;
#(
  parameter int WORD_W = CP_WORD_W,
  parameter int ADDR_W = CP_ADDR_W,
  parameter int DATA_W = CP_DATA_W,
  localparam int HDR_W = 1 + ADDR_W,
  localparam int CNT_W = $clog2(WORD_W + 1),
  localparam int SEL_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_evt,
  input  logic              fall_evt,
  input  logic              fs_i,
  input  logic              din_i,
  input  logic              status_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic              dout_o,
  output logic [ADDR_W-1:0] hdr_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              fs_evt,
  output logic              frame_sec,
  output logic              active,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              status_cap
);
  logic [WORD_W-1:0] shin;
  logic [WORD_W-1:0] next_word;
  logic [HDR_W-1:0]  hdr;
  logic              shift_evt;
  logic              word_full;
  logic              out_bit;
  logic [SEL_W-1:0]  sel;

  assign fs_evt    = fall_evt & fs_i;
  assign shift_evt = fall_evt & ~fs_i & active;
  assign word_full = shift_evt && (bit_cnt == CNT_W'(WORD_W - 1));
  assign next_word = {shin[WORD_W-2:0], din_i};

  assign wr_en   = word_full & frame_sec & ~word_is_read(next_word);
  assign wr_addr = word_addr(next_word);
  assign wr_data = word_data(next_word);

  assign hdr_addr = hdr[ADDR_W-1:0];
  assign sel      = SEL_W'(WORD_W - 1 - int'(bit_cnt));

  always_comb begin
    out_bit = 1'b0;
    if (active && frame_sec) begin
      if (bit_cnt < CNT_W'(HDR_W)) out_bit = status_cap;
      else if (hdr[HDR_W-1])       out_bit = rd_data[sel];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      frame_sec  <= 1'b1;
      bit_cnt    <= '0;
      shin       <= '0;
      hdr        <= '0;
      status_cap <= 1'b0;
      dout_o     <= 1'b0;
    end else begin
      if (fs_evt) begin
        active    <= 1'b1;
        frame_sec <= ~frame_sec;
        bit_cnt   <= '0;
        if (!frame_sec) status_cap <= status_s;
      end else if (shift_evt) begin
        shin    <= next_word;
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == CNT_W'(HDR_W - 1)) hdr <= next_word[HDR_W-1:0];
        if (word_full) active <= 1'b0;
      end
      if (rise_evt) dout_o <= out_bit;
    end
  end
endmodule

// File: rtl/codec_ctrl_port.sv
module codec_ctrl_port
  import codec_port_pkg::*;
#(
  parameter int DIV_STAGES  = 2,
  parameter int SYNC_STAGES = 2,
  parameter int REG_COUNT   = 4,
  parameter int FLAG_ADDR   = 2,
  localparam int WORD_W = CP_WORD_W,
  localparam int ADDR_W = CP_ADDR_W,
  localparam int DATA_W = CP_DATA_W,
  localparam int CNT_W  = $clog2(WORD_W + 1)
) (
  input  logic       mclk_i,
  input  logic       rst_ni,
  input  logic       fs_i,
  input  logic       din_i,
  input  logic       stat_i,
  output logic       sclk_o,
  output logic       dout_o,
  output logic [1:0] flag_o
);
  logic              rise_evt;
  logic              fall_evt;
  logic              fs_evt;
  logic              status_s;
  logic              status_cap;
  logic              frame_sec;
  logic              active;
  logic [CNT_W-1:0]  bit_cnt;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [ADDR_W-1:0] hdr_addr;
  logic [DATA_W-1:0] rd_data;

  codec_sclk_div #(.STAGES(DIV_STAGES)) u_div (
    .clk(mclk_i), .rst_n(rst_ni), .sclk_o(sclk_o),
    .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  codec_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(mclk_i), .rst_n(rst_ni), .d(stat_i), .q(status_s)
  );

  codec_frame_engine #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk(mclk_i), .rst_n(rst_ni), .rise_evt(rise_evt), .fall_evt(fall_evt),
    .fs_i(fs_i), .din_i(din_i), .status_s(status_s), .rd_data(rd_data),
    .dout_o(dout_o), .hdr_addr(hdr_addr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .fs_evt(fs_evt), .frame_sec(frame_sec), .active(active),
    .bit_cnt(bit_cnt), .status_cap(status_cap)
  );

  codec_reg_bank #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_COUNT(REG_COUNT),
    .FLAG_ADDR(FLAG_ADDR), .FLAG_W(2)
  ) u_regs (
    .clk(mclk_i), .rst_n(rst_ni), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(hdr_addr), .rd_data(rd_data), .flag_o(flag_o)
  );
endmodule

// File: rtl/codec_ctrl_port_chk.sv
module codec_ctrl_port_chk #(
  parameter int WORD_W    = 16,
  parameter int ADDR_W    = 7,
  parameter int FLAG_ADDR = 2,
  localparam int HDR_W = 1 + ADDR_W,
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rise_evt,
  input logic              fall_evt,
  input logic              fs_evt,
  input logic              active,
  input logic              frame_sec,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic              status_cap,
  input logic              dout_o,
  input logic [1:0]        flag_o,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr
);
  assert_sclk_rate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |-> ##2 fall_evt);

  assert_sclk_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> (!rise_evt && !fall_evt));

  assert_alternate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fs_evt |=> (frame_sec != $past(frame_sec)));

  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fs_evt |=> (active && bit_cnt == '0));

  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(WORD_W));

  assert_status_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt && active && frame_sec && bit_cnt < CNT_W'(HDR_W)) |=> (dout_o == status_cap));

  assert_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt && !(active && frame_sec)) |=> !dout_o);

  assert_flag_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(flag_o) |-> $past(wr_en));

  assert_flag_other_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != ADDR_W'(FLAG_ADDR)) |=> $stable(flag_o));
endmodule

bind codec_ctrl_port codec_ctrl_port_chk #(
  .WORD_W(WORD_W), .ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR)
) u_chk (
  .clk(mclk_i), .rst_n(rst_ni), .rise_evt(rise_evt), .fall_evt(fall_evt),
  .fs_evt(fs_evt), .active(active), .frame_sec(frame_sec), .bit_cnt(bit_cnt),
  .status_cap(status_cap), .dout_o(dout_o), .flag_o(flag_o),
  .wr_en(wr_en), .wr_addr(wr_addr)
);

// File: tb/codec_ctrl_port_test.sv
module codec_ctrl_port_test;
  logic       mclk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fs = 1'b0;
  logic       din = 1'b0;
  logic       stat = 1'b0;
  logic       sclk;
  logic       dout;
  logic [1:0] flag;

  int checks = 0;
  int errors = 0;
  logic [7:0] mreg [4];
  logic sec_next = 1'b0;

  always #2 mclk = ~mclk;

  codec_ctrl_port uut (
    .mclk_i(mclk), .rst_ni(rst_n), .fs_i(fs), .din_i(din), .stat_i(stat),
    .sclk_o(sclk), .dout_o(dout), .flag_o(flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [6:0] a);
    return (a < 7'd4) ? mreg[a[1:0]] : 8'h00;
  endfunction

  task automatic run_frame(input logic [15:0] w, input int nbits, input bit flip,
                           output logic [15:0] got, output logic [1:0] pre_flag);
    got = '0;
    pre_flag = flag;
    @(posedge sclk); #1 fs = 1'b1;
    @(posedge sclk); #1 fs = 1'b0; din = w[15];
    for (int i = 0; i < nbits; i++) begin
      @(negedge sclk); #1 got[15-i] = dout;
      if (i == 14) pre_flag = flag;
      if (flip && i == 3) stat = ~stat;
      if (i < nbits - 1) begin
        @(posedge sclk); #1 din = w[14-i];
      end
    end
    if (nbits == 16 && sec_next && !w[15] && w[14:8] < 7'd4) mreg[w[9:8]] = w[7:0];
    sec_next = ~sec_next;
  endtask

  task automatic sec_op(input logic [15:0] w, input bit flip, input bit lead, input string req);
    logic [15:0] g;
    logic [15:0] exp;
    logic [1:0]  pf;
    logic [1:0]  oldf;
    if (lead) begin
      run_frame(16'h0233, 16, 1'b0, g, pf);
      chk(g == 16'h0, "R11 sample frame output low", int'(g), 0);
      chk(flag == mreg[2][1:0], "R2 sample frame leaves flags", int'(flag), int'(mreg[2][1:0]));
    end
    exp  = {{8{stat}}, w[15] ? exp_rd(w[14:8]) : 8'h00};
    oldf = mreg[2][1:0];
    run_frame(w, 16, flip, g, pf);
    chk(g == exp, req, int'(g), int'(exp));
    if (!w[15] && w[14:8] == 7'd2) begin
      chk(pf == oldf, "R6 flags held before last bit", int'(pf), int'(oldf));
      chk(flag == mreg[2][1:0], "R6 flags follow write", int'(flag), int'(mreg[2][1:0]));
    end
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic s [16];
    logic [15:0] g;
    logic [1:0]  pf;
    int bad;
    for (int i = 0; i < 4; i++) mreg[i] = 8'h00;

    repeat (5) @(posedge mclk);
    #1;
    chk(flag == 2'b00, "R10 flags in reset", int'(flag), 0);
    chk(dout == 1'b0, "R10 dout in reset", int'(dout), 0);
    rst_n = 1'b1;
    repeat (3) @(posedge mclk);
    #1;
    chk(flag == 2'b00 && dout == 1'b0, "R10 outputs after reset", int'({flag, dout}), 0);

    // R1: sample the serial clock at master falling edges
    for (int i = 0; i < 16; i++) begin
      @(negedge mclk); s[i] = sclk;
    end
    bad = 0;
    for (int i = 0; i < 12; i++) begin
      if (s[i] == s[i+2] || s[i] != s[i+4]) bad++;
    end
    chk(bad == 0, "R1 divide by four", bad, 0);

    // R3 writes to each defined register, status alternating
    for (int a = 0; a < 4; a++) begin
      stat = a[0];
      sec_op({1'b0, 7'(a), 8'(a * 8'h4B + 8'h1D)}, 1'b0, 1'b1, "R3 write frame");
    end
    // R4 R5 reads with a junk data field
    for (int a = 0; a < 4; a++) begin
      stat = ~a[0];
      sec_op({1'b1, 7'(a), 8'hA5}, 1'b0, 1'b1, "R4 R5 read back");
    end
    // R6 every flag combination
    for (int v = 0; v < 4; v++) begin
      stat = v[1];
      sec_op({1'b0, 7'd2, 8'hA8 | 8'(v)}, 1'b0, 1'b1, "R6 flag write");
    end
    // R7 undefined address
    stat = 1'b1;
    sec_op({1'b0, 7'h64, 8'hFF}, 1'b0, 1'b1, "R7 undefined write");
    sec_op({1'b1, 7'h64, 8'h00}, 1'b0, 1'b1, "R7 undefined read zero");
    for (int a = 0; a < 4; a++) begin
      sec_op({1'b1, 7'(a), 8'h00}, 1'b0, 1'b1, "R7 defined registers intact");
    end
    chk(flag == 2'b11, "R7 flags intact", int'(flag), 3);
    // R8 status change after capture
    stat = 1'b1;
    sec_op({1'b1, 7'd1, 8'h00}, 1'b1, 1'b1, "R8 status held high");
    stat = 1'b0;
    sec_op({1'b1, 7'd3, 8'h00}, 1'b1, 1'b1, "R8 status held low");
    // R9 restart inside a word
    stat = 1'b0;
    run_frame(16'hFFFF, 5, 1'b0, g, pf);
    sec_op({1'b1, 7'd1, 8'h00}, 1'b0, 1'b0, "R9 restart after sample frame cut");
    run_frame(16'h1234, 16, 1'b0, g, pf);
    chk(g == 16'h0, "R11 sample frame output low", int'(g), 0);
    run_frame({1'b0, 7'd0, 8'h00}, 10, 1'b0, g, pf);
    sec_op({1'b1, 7'd0, 8'h00}, 1'b0, 1'b1, "R9 cut write has no effect");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule